// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block keeps the tag and valid state of a set-associative cache and nothing else: there is no data array. Each accepted access presents a byte address. The block splits the address into tag, set index and offset, compares the tag against every way of the indexed set and reports a hit or a miss one cycle later. The report also carries a way number. On a hit this is the way that matched. On a miss it is the way that received the new tag.

On a miss, an empty way in the set is always used first. When the set is full, a runtime policy input picks the line to replace. The choices are oldest-filled (FIFO), least-recently-accessed (LRU), and a reference-bit approximation of LRU whose bits are all cleared after a fixed number of accesses. All three trackers are kept up to date at all times over the same tag store, so the policy can be changed between accesses. Flush and reset both return the block to an empty cache.

Top module: `cache_tag_ctrl`

## Requirements
- R1: The set index is address bits [OFF_W+SET_W-1:OFF_W] and the tag is the bits above them. Addresses that differ only in the low OFF_W offset bits refer to the same line.
- R2: An access hits only if a valid way in the indexed set holds an equal tag. `way_o` then gives that way.
- R3: An access accepted at a clock edge (`acc_valid_i` high, `flush_i` low) gives `rsp_valid_o` high after that edge, with exactly one of `hit_o` and `miss_o` high. In any other cycle all three are low.
- R4: On a miss in a set that still has an invalid way, the lowest-numbered invalid way is filled, whatever the policy.
- R5: With `policy_i` = 0 (FIFO), a miss in a full set replaces the way that was filled earliest. Hits do not change this order.
- R6: With `policy_i` = 1 (LRU), a miss in a full set replaces the way whose latest hit or fill is oldest.
- R7: With `policy_i` = 2 or 3 (reference bits), every hit or fill sets the line's reference bit. A miss in a full set replaces the lowest-numbered way whose bit is clear, or way 0 if all bits in the set are set.
- R8: Every REF_PERIOD-th accepted access since reset or flush clears the reference bits of all sets. The line touched by that access then has its bit set.
- R9: With two ways and the line sequence A B C A B C B A B D in one set, FIFO gives 9 misses and LRU gives 8.
- R10: Replacement state is kept per set. Accesses to one set never change the victim chosen in another set.
- R11: Reset or `flush_i` invalidates every line and returns all policy state to its initial value. A flush takes priority over an access strobed in the same cycle, and that access gets no response.
- R12: With one way (direct-mapped), hit/miss results and `way_o` (always 0) do not depend on `policy_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Invalidate all lines and clear policy state |
| acc_valid_i | input | 1 | Access strobe |
| acc_addr_i | input | ADDR_W | Byte address of the access |
| policy_i | input | 2 | 0 FIFO, 1 LRU, 2 or 3 reference-bit |
| rsp_valid_o | output | 1 | Result present (one cycle after the access) |
| hit_o | output | 1 | Access hit |
| miss_o | output | 1 | Access missed; new tag installed |
| way_o | output | WAY_W | Way that hit, or way that was filled |

## Verification
The in-line properties check on every cycle that the response follows one cycle after each accepted strobe with hit and miss exclusive, and that a flush suppresses that response and empties the set state. They also check that a fill never skips a lower invalid way, and that in reference-bit mode a way whose bit is set is chosen only when the whole set has its bits set. The choice of victim under FIFO and LRU, the periodic clearing of reference bits, isolation between sets and the 9-versus-8 miss count depend on whole access histories. Only the bench's behavioural model shows these, comparing hit, miss and way on every response, together with the direct-mapped and two-way instances that run alongside it.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  typedef enum logic [1:0] {
    POL_FIFO  = 2'd0,
    POL_LRU   = 2'd1,
    POL_REF   = 2'd2,
    POL_REF_B = 2'd3
  } policy_e;
endpackage

// File: rtl/cache_tag_store.sv
// Tag array and valid bits; combinational lookup of the indexed set.
module cache_tag_store #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  parameter int SET_W = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             acc_en,
  input  logic [SET_W-1:0] set_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [WAY_W-1:0] fill_way_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic [WAYS-1:0]  valid_row_o
);
  // tag storage has no reset so it can map onto RAM
  logic [TAG_W-1:0] tag_mem [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];

  assign valid_row_o = valid_q[set_i];

  always_comb begin
    hit_o     = 1'b0;
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!hit_o && valid_q[set_i][w] && (tag_mem[set_i][w] == tag_i)) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc_en && !hit_o) tag_mem[set_i][fill_way_i] <= tag_i;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (acc_en && !hit_o) begin
      valid_q[set_i][fill_way_i] <= 1'b1;
    end
  end

  // R4
  lowest_invalid_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !hit_o && !(&valid_row_o)) |->
      (!valid_row_o[fill_way_i] &&
       ((valid_row_o & ((WAYS'(1) << fill_way_i) - WAYS'(1))) ==
        ((WAYS'(1) << fill_way_i) - WAYS'(1)))));

  // R11
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_row_o == '0));
endmodule

// File: rtl/cache_tag_policy.sv
// Per-set FIFO order, LRU order and reference bits; victim selection.
module cache_tag_policy
  import cache_tag_pkg::*;
#(
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int SET_W      = 4,
  parameter int WAY_W      = 2,
  parameter int REF_PERIOD = 64,
  parameter int CNT_W      = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             acc_en,
  input  logic [SET_W-1:0] set_i,
  input  logic             hit_i,
  input  logic [WAY_W-1:0] hit_way_i,
  input  logic [WAYS-1:0]  valid_row_i,
  input  policy_e          policy_i,
  output logic [WAY_W-1:0] fill_way_o
);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  // age ranks: 0 youngest, WAYS-1 oldest; each set holds a permutation
  logic [WAY_W-1:0] fifo_rk [SETS][WAYS];
  logic [WAY_W-1:0] lru_rk  [SETS][WAYS];
  logic [WAYS-1:0]  ref_q   [SETS];
  logic [CNT_W-1:0] ref_cnt;

  logic             inv_found;
  logic [WAY_W-1:0] inv_way, fifo_way, lru_way, ref_way, pol_way, touch_way;

  always_comb begin
    inv_found = 1'b0;
    inv_way   = '0;
    fifo_way  = '0;
    lru_way   = '0;
    ref_way   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!inv_found && !valid_row_i[w]) begin
        inv_found = 1'b1;
        inv_way   = WAY_W'(w);
      end
      if (fifo_rk[set_i][w] == OLDEST) fifo_way = WAY_W'(w);
      if (lru_rk[set_i][w] == OLDEST)  lru_way  = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!ref_q[set_i][w]) ref_way = WAY_W'(w);
    end
    case (policy_i)
      POL_FIFO: pol_way = fifo_way;
      POL_LRU:  pol_way = lru_way;
      default:  pol_way = ref_way;
    endcase
    fill_way_o = inv_found ? inv_way : pol_way;
    touch_way  = hit_i ? hit_way_i : fill_way_o;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          fifo_rk[s][w] <= WAY_W'(w);
          lru_rk[s][w]  <= WAY_W'(w);
        end
      end
    end else if (acc_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)                        lru_rk[set_i][w] <= '0;
        else if (lru_rk[set_i][w] < lru_rk[set_i][touch_way]) lru_rk[set_i][w] <= lru_rk[set_i][w] + 1'b1;
        if (!hit_i) begin
          if (WAY_W'(w) == touch_way)                          fifo_rk[set_i][w] <= '0;
          else if (fifo_rk[set_i][w] < fifo_rk[set_i][touch_way]) fifo_rk[set_i][w] <= fifo_rk[set_i][w] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int s = 0; s < SETS; s++) ref_q[s] <= '0;
      ref_cnt <= '0;
    end else if (acc_en) begin
      if (ref_cnt == CNT_W'(REF_PERIOD - 1)) begin
        for (int s = 0; s < SETS; s++) ref_q[s] <= '0;
        ref_cnt <= '0;
      end else begin
        ref_cnt <= ref_cnt + 1'b1;
      end
      ref_q[set_i][touch_way] <= 1'b1;
    end
  end

  // R7
  ref_victim_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !hit_i && (&valid_row_i) && (policy_i inside {POL_REF, POL_REF_B}) &&
     ref_q[set_i][fill_way_o]) |-> (&ref_q[set_i]));

  // R8
  ref_count_range_chk: assert property (@(posedge clk) disable iff (rst)
    ref_cnt < CNT_W'(REF_PERIOD));
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import cache_tag_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SET_W      = 4,
  parameter int OFF_W      = 4,
  parameter int WAYS       = 4,
  parameter int REF_PERIOD = 64,
  localparam int TAG_W     = ADDR_W - SET_W - OFF_W,
  localparam int SETS      = 1 << SET_W,
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int CNT_W     = $clog2(REF_PERIOD + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [1:0]        policy_i,
  output logic              rsp_valid_o,
  output logic              hit_o,
  output logic              miss_o,
  output logic [WAY_W-1:0]  way_o
);
  logic             acc_en;
  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] tag_val;
  logic             lk_hit;
  logic [WAY_W-1:0] lk_way, fill_way;
  logic [WAYS-1:0]  valid_row;

  assign acc_en  = acc_valid_i && !flush_i;
  assign set_idx = acc_addr_i[OFF_W +: SET_W];
  assign tag_val = acc_addr_i[ADDR_W-1 -: TAG_W];

  cache_tag_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_store (
    .clk(clk), .rst(rst), .flush(flush_i), .acc_en(acc_en),
    .set_i(set_idx), .tag_i(tag_val), .fill_way_i(fill_way),
    .hit_o(lk_hit), .hit_way_o(lk_way), .valid_row_o(valid_row)
  );

  cache_tag_policy #(
    .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W),
    .REF_PERIOD(REF_PERIOD), .CNT_W(CNT_W)
  ) u_policy (
    .clk(clk), .rst(rst), .flush(flush_i), .acc_en(acc_en),
    .set_i(set_idx), .hit_i(lk_hit), .hit_way_i(lk_way),
    .valid_row_i(valid_row), .policy_i(policy_e'(policy_i)),
    .fill_way_o(fill_way)
  );

  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      miss_o      <= 1'b0;
      way_o       <= '0;
    end else begin
      rsp_valid_o <= acc_en;
      hit_o       <= acc_en && lk_hit;
      miss_o      <= acc_en && !lk_hit;
      if (acc_en) way_o <= lk_hit ? lk_way : fill_way;
    end
  end

  // R3
  rsp_follows_chk: assert property (@(posedge clk) disable iff (rst)
    acc_en |=> rsp_valid_o);

  // R3
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(hit_o && miss_o) && ((hit_o || miss_o) == rsp_valid_o));

  // R11
  flush_drops_chk: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> !rsp_valid_o);
endmodule

// File: tb/cache_tag_ctrl_tb.sv
module cache_tag_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PER        = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        flush;
  logic        acc_valid;
  logic [11:0] acc_addr;
  logic [1:0]  policy;

  logic       rsp_v, hit, miss;
  logic [1:0] way;
  logic       dm_v, dm_hit, dm_miss;
  logic [0:0] dm_way;
  logic       w2_v, w2_hit, w2_miss;
  logic [0:0] w2_way;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cache_tag_ctrl #(.ADDR_W(12), .SET_W(2), .OFF_W(2), .WAYS(4), .REF_PERIOD(PER)) u_dut (
    .clk(clk), .rst(rst), .flush_i(flush), .acc_valid_i(acc_valid), .acc_addr_i(acc_addr),
    .policy_i(policy), .rsp_valid_o(rsp_v), .hit_o(hit), .miss_o(miss), .way_o(way));

  cache_tag_ctrl #(.ADDR_W(12), .SET_W(2), .OFF_W(2), .WAYS(1), .REF_PERIOD(PER)) u_dut_dm (
    .clk(clk), .rst(rst), .flush_i(flush), .acc_valid_i(acc_valid), .acc_addr_i(acc_addr),
    .policy_i(policy), .rsp_valid_o(dm_v), .hit_o(dm_hit), .miss_o(dm_miss), .way_o(dm_way));

  cache_tag_ctrl #(.ADDR_W(12), .SET_W(2), .OFF_W(2), .WAYS(2), .REF_PERIOD(PER)) u_dut_w2 (
    .clk(clk), .rst(rst), .flush_i(flush), .acc_valid_i(acc_valid), .acc_addr_i(acc_addr),
    .policy_i(policy), .rsp_valid_o(w2_v), .hit_o(w2_hit), .miss_o(w2_miss), .way_o(w2_way));

  int checks = 0;
  int errors = 0;
  int w2_misses = 0;

  // behavioural model of the 4-way instance: time stamps instead of ranks
  int  m_tag [4][4];
  bit  m_val [4][4];
  int  m_fill[4][4];
  int  m_use [4][4];
  bit  m_ref [4][4];
  int  m_cnt = 0;
  int  tstamp = 0;
  int  d_tag [4];
  bit  d_val [4];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_flush();
    for (int s = 0; s < 4; s++) begin
      d_val[s] = 0;
      for (int w = 0; w < 4; w++) begin
        m_val[s][w] = 0;
        m_ref[s][w] = 0;
      end
    end
    m_cnt = 0;
  endtask

  task automatic model_access(int addr, int pol, output int eh, output int ew, output string why);
    int s, t, best;
    s = (addr >> 2) & 3;
    t = addr >> 4;
    tstamp++;
    eh = 0; ew = 0; why = "R2";
    for (int w = 0; w < 4; w++)
      if (eh == 0 && m_val[s][w] && m_tag[s][w] == t) begin eh = 1; ew = w; end
    if (eh == 1) begin
      m_use[s][ew] = tstamp;
    end else begin
      best = -1;
      for (int w = 3; w >= 0; w--) if (!m_val[s][w]) best = w;
      if (best >= 0) begin
        ew = best; why = "R4";
      end else if (pol == 0) begin
        why = "R5"; ew = 0;
        for (int w = 1; w < 4; w++) if (m_fill[s][w] < m_fill[s][ew]) ew = w;
      end else if (pol == 1) begin
        why = "R6"; ew = 0;
        for (int w = 1; w < 4; w++) if (m_use[s][w] < m_use[s][ew]) ew = w;
      end else begin
        why = "R7"; ew = 0; best = -1;
        for (int w = 3; w >= 0; w--) if (!m_ref[s][w]) best = w;
        if (best >= 0) ew = best;
      end
      m_tag[s][ew]  = t;
      m_val[s][ew]  = 1;
      m_fill[s][ew] = tstamp;
      m_use[s][ew]  = tstamp;
    end
    m_cnt++;
    if (m_cnt == PER) begin
      for (int a = 0; a < 4; a++) for (int b = 0; b < 4; b++) m_ref[a][b] = 0;
      m_cnt = 0;
    end
    m_ref[s][ew] = 1;
  endtask

  // drive at a falling edge, check registered result at the next falling edge
  task automatic do_acc(int addr, int pol, string scen);
    int eh, ew, s, t, dh;
    string why;
    acc_valid = 1'b1;
    acc_addr  = 12'(addr);
    policy    = 2'(pol);
    model_access(addr, pol, eh, ew, why);
    s = (addr >> 2) & 3;
    t = addr >> 4;
    dh = (d_val[s] && d_tag[s] == t) ? 1 : 0;
    d_val[s] = 1; d_tag[s] = t;
    @(negedge clk);
    chk($sformatf("R3 %s rsp_valid", scen), int'(rsp_v), 1);
    chk($sformatf("%s %s hit", why, scen), int'(hit), eh);
    chk($sformatf("R3 %s miss", scen), int'(miss), 1 - eh);
    chk($sformatf("%s %s way", why, scen), int'(way), ew);
    chk($sformatf("R12 %s dm hit pol=%0d", scen, pol), int'(dm_hit), dh);
    chk($sformatf("R12 %s dm way", scen), int'(dm_way), 0);
    if (w2_miss) w2_misses++;
  endtask

  task automatic idle();
    acc_valid = 1'b0;
    @(negedge clk);
    chk("R3 idle rsp_valid", int'(rsp_v), 0);
    chk("R3 idle hit", int'(hit), 0);
  endtask

  task automatic do_flush();
    flush = 1'b1;
    acc_valid = 1'b1;
    acc_addr = 12'h010;
    @(negedge clk);
    chk("R11 flush drops access", int'(rsp_v), 0);
    flush = 1'b0;
    acc_valid = 1'b0;
    model_flush();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seq[10] = '{1, 2, 3, 1, 2, 3, 2, 1, 2, 4};
    logic [15:0] lfsr;
    rst = 1'b1; flush = 1'b0; acc_valid = 1'b0; acc_addr = '0; policy = '0;
    model_flush();
    repeat (3) @(negedge clk);
    chk("R11 reset rsp_valid", int'(rsp_v), 0);
    chk("R11 reset hit", int'(hit), 0);
    chk("R11 reset miss", int'(miss), 0);
    rst = 1'b0;
    @(negedge clk);

    // fills go to ways 0..3 in order, then FIFO eviction with hits between
    for (int i = 1; i <= 4; i++) do_acc(i * 16, 0, "fill");
    do_acc(16 + 3, 0, "R1 offset hit");
    do_acc(32 + 1, 0, "R1 offset hit");
    do_acc(5 * 16, 0, "fifo");
    do_acc(6 * 16, 0, "fifo");
    do_acc(16, 0, "fifo refill");
    idle();

    // LRU: hits reorder
    do_flush();
    for (int i = 1; i <= 4; i++) do_acc(i * 16 + 4, 1, "lru fill");
    do_acc(1 * 16 + 4, 1, "lru hit");
    do_acc(2 * 16 + 4, 1, "lru hit");
    do_acc(7 * 16 + 4, 1, "lru evict");
    do_acc(8 * 16 + 4, 1, "lru evict");

    // R10: activity in set 1 leaves set 0 order intact
    do_flush();
    for (int i = 1; i <= 4; i++) do_acc(i * 16, 1, "R10 set0");
    for (int i = 5; i <= 8; i++) do_acc(i * 16 + 4, 1, "R10 set1");
    do_acc(5 * 16 + 4, 1, "R10 set1 hit");
    do_acc(9 * 16, 1, "R10 set0 evict");
    chk("R10 set0 victim way", int'(way), 0);

    // R8: reference bits cleared on the PER-th access
    do_flush();
    for (int i = 1; i <= 4; i++) do_acc(i * 16 + 8, 2, "ref fill");
    do_acc(5 * 16 + 8, 2, "ref all set");
    chk("R7 all bits set picks way0", int'(way), 0);
    do_acc(2 * 16 + 8, 2, "ref hit");
    do_acc(3 * 16 + 8, 2, "ref hit");
    do_acc(5 * 16 + 8, 3, "ref hit clears");
    do_acc(6 * 16 + 8, 3, "R8 after clear");
    chk("R8 victim after periodic clear", int'(way), 1);

    // R9: A B C A B C B A B D on the 2-way instance
    for (int p = 0; p < 2; p++) begin
      do_flush();
      w2_misses = 0;
      for (int i = 0; i < 10; i++) do_acc(seq[i] * 16, p, "R9 trace");
      idle();
      chk($sformatf("R9 miss count pol=%0d", p), w2_misses, (p == 0) ? 9 : 8);
    end

    // mixed traffic, policy changing, compared every response
    do_flush();
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 200 == 199) do_flush();
      else do_acc(((int'(lfsr[10:8]) % 6 + 1) << 4) | int'(lfsr[3:0]), (i / 37) % 4, "mixed");
    end
    idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule